// File: doc/BRIEF.md
# Bus Drop Frame Controller

This block sits at a guest position on a shared serial bus. Each guest has a static address. An upstream stage aligns the bytes and presents each frame as one strobe with its fields: a token count, a channel bit, a 5-bit tap address and two data words. Each frame serves as a time base. It raises a tick and advances a counter that every guest on the bus keeps in step. A tap of zero restarts that counter. A tap equal to this guest's own address opens its slot on the shared return line.

Data words that carry a token are collected into packets, one per channel. A packet ends when its channel sends a frame with a zero token. Channel A packets are always handed to the application. A channel B packet starts with a destination address and a flow-control byte. Only a packet whose destination equals this guest's address has its payload delivered. Packets are stored until they end, so an oversized packet can be discarded whole. Spare data slots and matching channel B packets both carry the partner's free receive-buffer count, and the block keeps the latest value.

Top module: `dropFrameCtrl`

## Requirements
- R1: Each cycle with `frameValid` high makes `tick` high for exactly the next cycle. In that same next cycle `tickCount` shows its previous value plus one, modulo 2^CNT_W, unless R2 applies.
- R2: A frame whose `frameTap` is 0 sets `tickCount` to 0 in the cycle after the frame, and still produces its tick.
- R3: `txGrant` is high for one cycle, the cycle after a frame, exactly when `frameTap` equals `myAddr` and `myAddr` is not 0. It is never high otherwise.
- R4: `frameToken` gives the number of data words in the frame that belong to the packet: 0, 1 (`frameWord0` only) or 2 (`frameWord0` then `frameWord1`). The code 3 is treated as 2. Packet bytes keep their arrival order.
- R5: A channel's packet ends when a zero-token frame arrives on that channel after one or more nonzero-token frames on it. The stored bytes then leave on the channel's stream one per cycle, starting the cycle after the ending frame. The end flag is high only on the last byte. A zero-token frame on a channel with no open packet emits nothing.
- R6: `frameChan` 0 selects channel A and 1 selects channel B. Each channel keeps its own packet, so frames on one channel neither end nor alter a packet open on the other.
- R7: A complete channel B packet emits its bytes from index 2 onward only if byte 0 equals `myAddr` zero-extended to 8 bits. Otherwise, or if the packet has 2 bytes or fewer, it emits nothing.
- R8: Every frame with `frameToken` 0 or 1 loads `frameWord1` into `remoteCredit`, visible the cycle after. Frames with token 2 or 3 leave it unchanged.
- R9: When a matching channel B packet of at least 2 bytes ends, its byte 1 is loaded into `remoteCredit`. This takes priority over R8 for the ending frame.
- R10: A packet that would grow past MAX_LEN bytes emits no bytes and loads no credit. At its ending frame, that channel's overflow output pulses high for one cycle, the cycle after the ending frame.
- R11: After reset, `tick`, `tickCount`, `txGrant`, `remoteCredit` and all stream, end and overflow outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe of a decoded frame |
| frameToken | input | 2 | Count of packet-carrying data words |
| frameChan | input | 1 | 0 = channel A, 1 = channel B |
| frameTap | input | ADDR_W | Tap address of the frame |
| frameWord0 | input | 8 | First data word |
| frameWord1 | input | 8 | Second data word |
| myAddr | input | ADDR_W | Static address of this guest |
| tick | output | 1 | One-cycle tick per frame |
| tickCount | output | CNT_W | Shared tick counter |
| txGrant | output | 1 | Uplink slot granted to this guest |
| aValid | output | 1 | Channel A byte valid |
| aData | output | 8 | Channel A byte |
| aEop | output | 1 | Last byte of a channel A packet |
| aOverflow | output | 1 | Channel A packet dropped for length |
| bValid | output | 1 | Channel B payload byte valid |
| bData | output | 8 | Channel B payload byte |
| bEop | output | 1 | Last byte of a channel B payload |
| bOverflow | output | 1 | Channel B packet dropped for length |
| remoteCredit | output | 8 | Partner's latest free-buffer count |

## Verification
The assertions assume that frames are spaced widely. No frame may arrive while a finished packet is still leaving the block, and that window lasts up to MAX_LEN cycles. This matches a bus that delivers one frame per several hundred cycles. The bench sends each frame and then leaves twelve idle cycles, which is more than MAX_LEN in its small configuration. The stream therefore never overlaps new stimulus. The bench uses a 4-bit counter so that the wrap is reached, and it sweeps every tap value and every packet length up to two past the limit.

// File: rtl/dropFramePkg.sv
package dropFramePkg;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chanT;

  // strobes from control to datapath, bit index = channel
  typedef struct packed {
    logic [1:0] push;
    logic [1:0] two;
    logic       slotCredit;
    logic       pktCredit;
  } dpStrobeT;

  function automatic logic [1:0] effTokens(input logic [1:0] tok);
    return (tok == 2'd3) ? 2'd2 : tok;
  endfunction

endpackage

// File: rtl/dropFrameCtl.sv
module dropFrameCtl
  import dropFramePkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 5,
  parameter int WORD_W  = 8,
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameValid,
  input  logic [1:0]             frameToken,
  input  logic                   frameChan,
  input  logic [ADDR_W-1:0]      frameTap,
  input  logic [ADDR_W-1:0]      myAddr,
  input  logic [WORD_W-1:0]      headByte,
  output logic                   tick,
  output logic [CNT_W-1:0]       tickCount,
  output logic                   txGrant,
  output dpStrobeT               strobe,
  output logic [1:0][IDX_W-1:0]  wrIdx,
  output logic [1:0][IDX_W-1:0]  rdIdx,
  output logic [1:0]             outValid,
  output logic [1:0]             outLast,
  output logic [1:0]             overflow
);

  logic [1:0]       tokN;
  logic             headMatch;
  logic [1:0]       hit;
  logic [1:0]       closing;
  logic [1:0]       fits;
  logic [1:0]       deliver;
  logic [1:0][LEN_W-1:0] lenV;
  logic [1:0]       openV;
  logic [1:0]       ovfV;

  assign tokN      = effTokens(frameToken);
  assign headMatch = (headByte == WORD_W'(myAddr));

  // time base and uplink slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick      <= 1'b0;
      txGrant   <= 1'b0;
      tickCount <= '0;
    end else begin
      tick    <= frameValid;
      txGrant <= frameValid && (frameTap == myAddr) && (myAddr != '0);
      if (frameValid) begin
        if (frameTap == '0) tickCount <= '0;
        else                tickCount <= tickCount + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : gChan
    logic [LEN_W-1:0] lenR;
    logic [LEN_W:0]   grown;
    logic             openR, ovfR, drainR, ovfPulseR;
    logic [IDX_W-1:0] rdR, lastR;
    logic [IDX_W-1:0] firstIdx;

    assign hit[c]     = frameValid && (frameChan == c[0]);
    assign closing[c] = hit[c] && (tokN == 2'd0) && openR;
    assign grown      = {1'b0, lenR} + (LEN_W+1)'(tokN);
    assign fits[c]    = (grown <= (LEN_W+1)'(MAX_LEN));
    assign lenV[c]    = lenR;
    assign openV[c]   = openR;
    assign ovfV[c]    = ovfR;

    if (c == 0) begin : gLeadA
      assign firstIdx   = '0;
      assign deliver[c] = (lenR != '0);
    end else begin : gLeadB
      assign firstIdx   = IDX_W'(2);
      assign deliver[c] = (lenR > LEN_W'(2)) && headMatch;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lenR      <= '0;
        openR     <= 1'b0;
        ovfR      <= 1'b0;
        drainR    <= 1'b0;
        ovfPulseR <= 1'b0;
        rdR       <= '0;
        lastR     <= '0;
      end else begin
        ovfPulseR <= 1'b0;
        if (drainR) begin
          if (rdR == lastR) drainR <= 1'b0;
          else              rdR    <= rdR + 1'b1;
        end
        if (hit[c] && (tokN != 2'd0)) begin
          openR <= 1'b1;
          if (!ovfR && fits[c]) lenR <= grown[LEN_W-1:0];
          else                  ovfR <= 1'b1;
        end else if (closing[c]) begin
          openR <= 1'b0;
          ovfR  <= 1'b0;
          lenR  <= '0;
          if (ovfR) begin
            ovfPulseR <= 1'b1;
          end else if (deliver[c]) begin
            drainR <= 1'b1;
            rdR    <= firstIdx;
            lastR  <= IDX_W'(lenR - 1'b1);
          end
        end
      end
    end

    assign wrIdx[c]     = lenR[IDX_W-1:0];
    assign rdIdx[c]     = rdR;
    assign outValid[c]  = drainR;
    assign outLast[c]   = drainR && (rdR == lastR);
    assign overflow[c]  = ovfPulseR;
    assign strobe.push[c] = hit[c] && (tokN != 2'd0) && !ovfR && fits[c];
    assign strobe.two[c]  = (tokN == 2'd2);

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      lenR <= LEN_W'(MAX_LEN)); // R10
    AST_OVF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovfPulseR) |-> !$rose(drainR)); // R10
    AST_EOP_IN_STREAM: assert property (@(posedge clk) disable iff (!rstN)
      (drainR && rdR == lastR) |=> !drainR); // R5
  end

  assign strobe.slotCredit = frameValid && (frameToken < 2'd2);
  assign strobe.pktCredit  = closing[1] && !ovfV[1] &&
                             (lenV[1] >= LEN_W'(2)) && headMatch;

  AST_TICK_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> tick); // R1
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(frameValid)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameTap != '0) |=> tickCount == $past(tickCount) + 1'b1); // R1
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameTap == '0) |=> tickCount == '0); // R2
  AST_GRANT_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |-> $past(frameValid && frameTap == myAddr && myAddr != '0)); // R3
  AST_QUIET_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid) |-> !frameValid); // R5
  AST_CHAN_ISOLATE: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameChan == CH_B) |=> $stable(lenV[0]) && $stable(openV[0])); // R6

endmodule

// File: rtl/dropFrameData.sv
module dropFrameData
  import dropFramePkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int WORD_W  = 8,
  parameter int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobeT               strobe,
  input  logic [WORD_W-1:0]      frameWord0,
  input  logic [WORD_W-1:0]      frameWord1,
  input  logic [1:0][IDX_W-1:0]  wrIdx,
  input  logic [1:0][IDX_W-1:0]  rdIdx,
  output logic [1:0][WORD_W-1:0] outData,
  output logic [WORD_W-1:0]      headByte,
  output logic [WORD_W-1:0]      remoteCredit
);

  logic [WORD_W-1:0] credByte;

  for (genvar c = 0; c < 2; c++) begin : gBuf
    logic [WORD_W-1:0] mem [MAX_LEN];

    always_ff @(posedge clk) begin
      if (strobe.push[c]) begin
        mem[wrIdx[c]] <= frameWord0;
        if (strobe.two[c]) mem[IDX_W'(wrIdx[c] + 1'b1)] <= frameWord1;
      end
    end

    assign outData[c] = mem[rdIdx[c]];

    if (c == 1) begin : gHead
      assign headByte = mem[0];
      assign credByte = mem[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  remoteCredit <= '0;
    else if (strobe.pktCredit)  remoteCredit <= credByte;
    else if (strobe.slotCredit) remoteCredit <= frameWord1;
  end

  AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.slotCredit && !strobe.pktCredit) |=> $stable(remoteCredit)); // R8
  AST_CREDIT_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pktCredit |=> remoteCredit == $past(credByte)); // R9

endmodule

// File: rtl/dropFrameCtrl.sv
module dropFrameCtrl
  import dropFramePkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [1:0]        frameToken,
  input  logic              frameChan,
  input  logic [ADDR_W-1:0] frameTap,
  input  logic [7:0]        frameWord0,
  input  logic [7:0]        frameWord1,
  input  logic [ADDR_W-1:0] myAddr,
  output logic              tick,
  output logic [CNT_W-1:0]  tickCount,
  output logic              txGrant,
  output logic              aValid,
  output logic [7:0]        aData,
  output logic              aEop,
  output logic              aOverflow,
  output logic              bValid,
  output logic [7:0]        bData,
  output logic              bEop,
  output logic              bOverflow,
  output logic [7:0]        remoteCredit
);

  localparam int WORD_W = 8;
  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam int LEN_W  = $clog2(MAX_LEN + 1);

  dpStrobeT                 strobe;
  logic [1:0][IDX_W-1:0]    wrIdx;
  logic [1:0][IDX_W-1:0]    rdIdx;
  logic [1:0]               outValid;
  logic [1:0]               outLast;
  logic [1:0]               overflow;
  logic [1:0][WORD_W-1:0]   outData;
  logic [WORD_W-1:0]        headByte;

  dropFrameCtl #(
    .MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .WORD_W(WORD_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) uCtl (
    .clk(clk), .rstN(rstN),
    .frameValid(frameValid), .frameToken(frameToken),
    .frameChan(frameChan), .frameTap(frameTap),
    .myAddr(myAddr), .headByte(headByte),
    .tick(tick), .tickCount(tickCount), .txGrant(txGrant),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .outValid(outValid), .outLast(outLast), .overflow(overflow)
  );

  dropFrameData #(
    .MAX_LEN(MAX_LEN), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .frameWord0(frameWord0), .frameWord1(frameWord1),
    .wrIdx(wrIdx), .rdIdx(rdIdx),
    .outData(outData), .headByte(headByte),
    .remoteCredit(remoteCredit)
  );

  assign aValid    = outValid[CH_A];
  assign aData     = outValid[CH_A] ? outData[CH_A] : '0;
  assign aEop      = outLast[CH_A];
  assign aOverflow = overflow[CH_A];
  assign bValid    = outValid[CH_B];
  assign bData     = outValid[CH_B] ? outData[CH_B] : '0;
  assign bEop      = outLast[CH_B];
  assign bOverflow = overflow[CH_B];

  AST_EOP_VALID_A: assert property (@(posedge clk) disable iff (!rstN)
    aEop |-> aValid); // R5
  AST_EOP_VALID_B: assert property (@(posedge clk) disable iff (!rstN)
    bEop |-> bValid); // R7

endmodule

// File: tb/dropFrameCtrl_bench.sv
`timescale 1ns/1ps
module dropFrameCtrl_bench;

  localparam int MAXL = 8;
  localparam int CW   = 4;
  localparam int GAP  = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0;
  logic [1:0] frameToken = '0;
  logic       frameChan = 1'b0;
  logic [4:0] frameTap = '0;
  logic [7:0] frameWord0 = '0;
  logic [7:0] frameWord1 = '0;
  logic [4:0] myAddr = 5'd3;
  logic       tick, txGrant, aValid, aEop, aOverflow, bValid, bEop, bOverflow;
  logic [CW-1:0] tickCount;
  logic [7:0] aData, bData, remoteCredit;

  always #4 clk = ~clk;

  dropFrameCtrl #(.MAX_LEN(MAXL), .CNT_W(CW), .ADDR_W(5)) u_dropFrameCtrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameToken(frameToken),
    .frameChan(frameChan), .frameTap(frameTap), .frameWord0(frameWord0),
    .frameWord1(frameWord1), .myAddr(myAddr), .tick(tick), .tickCount(tickCount),
    .txGrant(txGrant), .aValid(aValid), .aData(aData), .aEop(aEop),
    .aOverflow(aOverflow), .bValid(bValid), .bData(bData), .bEop(bEop),
    .bOverflow(bOverflow), .remoteCredit(remoteCredit)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  int expCount = 0;

  logic [7:0] gotA [64];
  logic [7:0] gotB [64];
  int nA = 0, nB = 0, eopA = 0, eopB = 0, eopPosA = -1, eopPosB = -1;
  int ovfA = 0, ovfB = 0;
  logic [7:0] pkt [32];

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (aValid) begin
      gotA[nA] = aData;
      if (aEop) begin eopA++; eopPosA = nA; end
      nA++;
    end
    if (bValid) begin
      gotB[nB] = bData;
      if (bEop) begin eopB++; eopPosB = nB; end
      nB++;
    end
    if (aOverflow) ovfA++;
    if (bOverflow) ovfB++;
  end

  task automatic clearCapture();
    nA = 0; nB = 0; eopA = 0; eopB = 0; eopPosA = -1; eopPosB = -1;
    ovfA = 0; ovfB = 0;
  endtask

  // one frame, checks of tick/count/grant in the cycle after it
  task automatic sendFrame(input logic [1:0] tok, input logic ch, input logic [4:0] tap,
                           input logic [7:0] w0, input logic [7:0] w1);
    @(negedge clk);
    frameValid = 1'b1; frameToken = tok; frameChan = ch;
    frameTap = tap; frameWord0 = w0; frameWord1 = w1;
    @(negedge clk);
    frameValid = 1'b0;
    expCount = (tap == 0) ? 0 : (expCount + 1) % (1 << CW);
    check({31'd0, tick}, 32'd1, "R1 tick");
    check({28'd0, tickCount}, expCount, (tap == 0) ? "R2 count clear" : "R1 count step");
    check({31'd0, txGrant}, {31'd0, (tap == myAddr) && (myAddr != 0)}, "R3 grant");
    repeat (GAP) @(negedge clk);
    check({31'd0, tick}, 32'd0, "R1 tick single");
  endtask

  // sends pkt[0..len-1] on ch, then the ending frame
  task automatic sendPacket(input logic ch, input int len, input logic [7:0] eopW1);
    int i = 0;
    while (i < len) begin
      if (len - i >= 2) begin
        sendFrame((len % 2 == 1) ? 2'd3 : 2'd2, ch, 5'd7, pkt[i], pkt[i+1]); // R4 code 3
        i += 2;
      end else begin
        sendFrame(2'd1, ch, 5'd7, pkt[i], 8'hC0);
        i += 1;
      end
    end
    sendFrame(2'd0, ch, 5'd7, 8'h00, eopW1);
  endtask

  task automatic verifyA(input int expN, input int first, input string tag);
    check(nA, expN, {tag, " count"});
    for (int k = 0; k < expN && k < nA; k++) check({24'd0, gotA[k]}, {24'd0, pkt[first+k]}, {tag, " byte"});
    check(eopA, (expN > 0) ? 1 : 0, {tag, " eop count"});
    if (expN > 0) check(eopPosA, expN - 1, {tag, " eop position"});
  endtask

  task automatic verifyB(input int expN, input int first, input string tag);
    check(nB, expN, {tag, " count"});
    for (int k = 0; k < expN && k < nB; k++) check({24'd0, gotB[k]}, {24'd0, pkt[first+k]}, {tag, " byte"});
    check(eopB, (expN > 0) ? 1 : 0, {tag, " eop count"});
    if (expN > 0) check(eopPosB, expN - 1, {tag, " eop position"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check({31'd0, tick}, 0, "R11 tick");
    check({28'd0, tickCount}, 0, "R11 count");
    check({31'd0, txGrant}, 0, "R11 grant");
    check({24'd0, remoteCredit}, 0, "R11 credit");
    check({28'd0, aValid, bValid, aOverflow, bOverflow}, 0, "R11 streams");

    // R1 counter steps and wraps (4-bit) under a nonzero tap
    for (int n = 0; n < 20; n++) sendFrame(2'd2, 1'b1, 5'd9, 8'h00, 8'h00);
    sendFrame(2'd0, 1'b1, 5'd9, 8'h00, 8'h00); // close that channel B packet (overflowed)
    check(ovfB, 1, "R10 long B dropped");
    check(nB, 0, "R10 no B bytes");
    clearCapture();

    // R2 tap zero clears, then counting resumes
    sendFrame(2'd0, 1'b0, 5'd0, 8'h00, 8'h00);
    sendFrame(2'd0, 1'b0, 5'd4, 8'h00, 8'h00);

    // R3 sweep every tap value for two addresses, then address zero
    for (int a = 1; a <= 2; a++) begin
      myAddr = (a == 1) ? 5'd3 : 5'd31;
      for (int t = 0; t < 32; t++) sendFrame(2'd0, 1'b0, 5'(t), 8'h00, 8'h00);
    end
    myAddr = 5'd0;
    sendFrame(2'd0, 1'b0, 5'd0, 8'h00, 8'h00); // R3 no grant for address 0
    myAddr = 5'd3;

    // R8 slot credit
    sendFrame(2'd0, 1'b0, 5'd7, 8'h11, 8'h42);
    check({24'd0, remoteCredit}, 8'h42, "R8 token0 credit");
    sendFrame(2'd2, 1'b0, 5'd7, 8'h11, 8'h99);
    check({24'd0, remoteCredit}, 8'h42, "R8 token2 keeps credit");
    sendFrame(2'd3, 1'b0, 5'd7, 8'h12, 8'h98);
    check({24'd0, remoteCredit}, 8'h42, "R8 token3 keeps credit");
    sendFrame(2'd1, 1'b0, 5'd7, 8'h13, 8'h43);
    check({24'd0, remoteCredit}, 8'h43, "R8 token1 credit");
    sendFrame(2'd0, 1'b0, 5'd7, 8'h00, 8'h44);
    check({24'd0, remoteCredit}, 8'h44, "R8 ending frame credit");
    pkt[0] = 8'h11; pkt[1] = 8'h99; pkt[2] = 8'h12; pkt[3] = 8'h98; pkt[4] = 8'h13;
    verifyA(5, 0, "R4 token codes A");
    clearCapture();

    // R5 R4 channel A length sweep; R10 overflow beyond MAXL
    for (int len = 1; len <= MAXL + 2; len++) begin
      for (int k = 0; k < len; k++) pkt[k] = 8'(len * 16 + k);
      sendPacket(1'b0, len, 8'h50);
      if (len <= MAXL) begin
        verifyA(len, 0, "R5 A packet");
        check(ovfA, 0, "R10 no overflow");
      end else begin
        check(nA, 0, "R10 A dropped");
        check(ovfA, 1, "R10 A overflow pulse");
      end
      clearCapture();
    end
    // R5 zero token with nothing open
    sendFrame(2'd0, 1'b0, 5'd7, 8'h00, 8'h00);
    check(nA, 0, "R5 idle zero token");

    // R7 R9 channel B sweep with matching destination
    for (int len = 1; len <= MAXL + 1; len++) begin
      pkt[0] = 8'd3; pkt[1] = 8'(8'hA0 + len);
      for (int k = 2; k < len; k++) pkt[k] = 8'(len * 8 + k);
      sendPacket(1'b1, len, 8'h5A);
      if (len <= MAXL) begin
        verifyB((len > 2) ? len - 2 : 0, 2, "R7 B match");
        check({24'd0, remoteCredit}, (len >= 2) ? {24'd0, pkt[1]} : 32'h5A, "R9 packet credit");
      end else begin
        check(nB, 0, "R10 B dropped");
        check(ovfB, 1, "R10 B overflow pulse");
        check({24'd0, remoteCredit}, 32'h5A, "R10 no credit from dropped");
      end
      clearCapture();
    end

    // R7 mismatching destinations
    for (int d = 0; d < 3; d++) begin
      pkt[0] = (d == 0) ? 8'd4 : ((d == 1) ? 8'h23 : 8'd0);
      pkt[1] = 8'hEE; pkt[2] = 8'h01; pkt[3] = 8'h02;
      sendPacket(1'b1, 4, 8'h61);
      verifyB(0, 2, "R7 B mismatch");
      check({24'd0, remoteCredit}, 32'h61, "R9 no credit on mismatch");
      clearCapture();
    end

    // R6 interleaved channels
    pkt[0] = 8'h01; pkt[1] = 8'h02; pkt[2] = 8'h03;
    pkt[8] = 8'd3; pkt[9] = 8'h55; pkt[10] = 8'h09; pkt[11] = 8'h0A;
    sendFrame(2'd2, 1'b0, 5'd7, 8'h01, 8'h02);
    sendFrame(2'd2, 1'b1, 5'd7, 8'd3, 8'h55);
    sendFrame(2'd1, 1'b0, 5'd7, 8'h03, 8'h70);
    sendFrame(2'd2, 1'b1, 5'd7, 8'h09, 8'h0A);
    sendFrame(2'd0, 1'b1, 5'd7, 8'h00, 8'h77);
    check(nA, 0, "R6 B end leaves A open");
    verifyB(2, 10, "R6 B interleaved");
    check({24'd0, remoteCredit}, 32'h55, "R9 packet credit wins");
    sendFrame(2'd0, 1'b0, 5'd7, 8'h00, 8'h66);
    verifyA(3, 0, "R6 A interleaved");
    check({24'd0, remoteCredit}, 32'h66, "R8 slot credit after A end");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule